// File: doc/BRIEF.md
# Four-Channel DMA Register Interface

This block is the software-visible register file of a four-channel DMA controller. A host issues byte-wide reads and writes on a small port window. Eight offsets reach the per-channel 16-bit start address and transfer count registers. The other eight offsets run the control functions: command, software request, single-channel mask, channel mode, byte-pointer clear, master clear, mask clear and whole-mask load. A separate transfer engine takes the current address, count, mode, mask and request state from the outputs. It reports its progress back through a count-advance strobe and a terminal-count strobe for each channel.

Every 16-bit register is reached through one byte-pointer flip-flop that all four channels share. The flip-flop chooses the low or the high byte, and every channel register access flips it. Writing the high byte loads the register and also restarts the channel's transfer position. The `SHIFT` parameter sets the controller for byte-wide or word-wide transfers. The bus address is shifted right by `SHIFT` before decoding. Current addresses are held in units of `SHIFT`, and each engine step moves the count by `1 << SHIFT`.

Top module: `dma_regif`

## Requirements
- R1: The register index is `addr >> SHIFT`, taken to 4 bits. Address bits below `SHIFT` have no effect.
- R2: For a channel register, index bit 0 selects count (1) or address (0) and index bits 2:1 select the channel. The shared byte pointer starts at 0. While it is 0 an access reaches the low byte, and while it is 1 the high byte. It flips after every channel-register read or write. A write to index 12 clears it.
- R3: A high-byte write to either register of a channel loads `cur_addr = start_address << SHIFT` and `cur_cnt = 0`. This reload wins over a count advance for that channel in the same cycle. A low-byte write leaves both current values unchanged.
- R4: A channel read returns bits `[SHIFT + 8*pointer +: 8]` of a view value. For the count register the view is `(start_count << SHIFT) - cur_cnt`. For the address register it is `cur_addr - cur_cnt` when mode bit 5 is set and `cur_addr + cur_cnt` otherwise. Read data appears on `rdata` with `rd_valid` high in the cycle after `rd_en`.
- R5: A write to index 8 stores the command byte. `cmd_disable` shows command bit 2. `cmd_unsup` becomes 1 if the byte has any bit of 0xFB set, and becomes 0 otherwise.
- R6: A write to index 9 targets channel `d[1:0]`. With `d[2]=1` it sets request bit 4+ch. With `d[2]=0` it clears request bit 4+ch and terminal-count bit ch. `req_o` carries status bits 7:4.
- R7: A write to index 10 sets mask bit `d[1:0]` when `d[2]=1` and clears it when `d[2]=0`. A write to index 14 clears all mask bits. A write to index 15 loads the mask from `d[3:0]`.
- R8: A write to index 11 stores the whole byte as the mode of channel `d[1:0]`.
- R9: A write to index 13 (master clear) zeroes the command, `cmd_unsup`, the status and the byte pointer, and sets all mask bits. Start, current and mode values are kept.
- R10: A read of index 8 returns status `{request[3:0], tc[3:0]}` and then clears the four terminal-count bits. A read of index 9 returns `{4'b0, mask}`. Reads of indexes 10 to 15 return 0x00.
- R11: `eng_tc[ch]` sets terminal-count bit ch. This set wins over every clear in the same cycle, whether from a status read, a request clear or a master clear.
- R12: `eng_adv[ch]` adds `1 << SHIFT` to that channel's `cur_cnt`.
- R13: The synchronous reset zeroes all registers except the mask, which it sets to 0xF. It also drops `rd_valid`.
- R14: When `wr_en` and `rd_en` are high together, only the write takes place and no read data is returned.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 4+SHIFT | Port address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| rd_valid | output | 1 | rdata valid |
| eng_adv | input | 4 | Per-channel count advance from the engine |
| eng_tc | input | 4 | Per-channel terminal-count set from the engine |
| chan_mode | output | 32 | Mode bytes, channel c at [8c +: 8] |
| chan_base_cnt | output | 64 | Start counts, channel c at [16c +: 16] |
| chan_cur_addr | output | 4*(16+SHIFT) | Current addresses |
| chan_cur_cnt | output | 4*(16+SHIFT) | Current transferred counts |
| mask_o | output | 4 | Channel mask bits |
| req_o | output | 4 | Software request bits |
| cmd_disable | output | 1 | Command bit 2 |
| cmd_unsup | output | 1 | Last command had an unsupported bit |

## Verification
The two functions that can land in the same cycle are a status read or request clear, and an engine terminal-count strobe on the same bit. Also colliding are a high-byte write and an engine count advance on the same channel. The bench holds `eng_tc` high during the status-read cycle and expects that read to return the old status, with the next read showing the bit set. It drives `eng_adv` during a high-byte write and expects the current count to be zero afterwards. A combined write-and-read strobe is judged by the write taking effect and no read data arriving.

// File: rtl/dma_regif_pkg.sv
package dma_regif_pkg;

    localparam int NCH    = 4;
    localparam int CH_W   = 2;
    localparam int BASE_W = 16;
    localparam int BYTE_W = 8;
    localparam int IDX_W  = 4;

    // bit positions of the mode byte that the register file itself uses
    localparam int MODE_DEC_BIT = 5;
    // command bits that request functions this controller does not offer
    localparam logic [BYTE_W-1:0] CMD_UNSUP_BITS = 8'hFB;
    localparam int CMD_DISABLE_BIT = 2;

    typedef enum logic [2:0] {
        OP_CMD     = 3'd0,
        OP_REQ     = 3'd1,
        OP_SMASK   = 3'd2,
        OP_MODE    = 3'd3,
        OP_CLRFF   = 3'd4,
        OP_MCLR    = 3'd5,
        OP_CLRMASK = 3'd6,
        OP_LDMASK  = 3'd7
    } ctl_op_e;

    typedef struct packed {
        logic            in_chan;
        logic [CH_W-1:0] chan;
        logic            sel_cnt;
        ctl_op_e         op;
    } port_sel_t;

    function automatic port_sel_t decode_index(input logic [IDX_W-1:0] idx);
        port_sel_t s;
        s.in_chan = ~idx[3];
        s.chan    = idx[2:1];
        s.sel_cnt = idx[0];
        s.op      = ctl_op_e'(idx[2:0]);
        return s;
    endfunction

endpackage

// File: rtl/dma_regif_decode.sv
module dma_regif_decode
    import dma_regif_pkg::*;
#(
    parameter int SHIFT = 0
) (
    input  logic [IDX_W+SHIFT-1:0] addr,
    input  logic                   wr_en,
    input  logic                   rd_en,
    output port_sel_t              sel,
    output logic                   do_wr,
    output logic                   do_rd
);
    logic [IDX_W-1:0] idx;

    always_comb begin
        idx   = addr[SHIFT +: IDX_W];
        sel   = decode_index(idx);
        do_wr = wr_en;
        do_rd = rd_en & ~wr_en;
    end
endmodule

// File: rtl/dma_regif_chan.sv
module dma_regif_chan
    import dma_regif_pkg::*;
#(
    parameter int SHIFT = 0,
    localparam int CA_W = BASE_W + SHIFT
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              base_we,
    input  logic              sel_cnt,
    input  logic              hi_byte,
    input  logic [BYTE_W-1:0] wdata,
    input  logic              mode_we,
    input  logic              adv,
    output logic [BYTE_W-1:0] mode,
    output logic [BASE_W-1:0] base_cnt,
    output logic [CA_W-1:0]   cur_addr,
    output logic [CA_W-1:0]   cur_cnt,
    output logic [CA_W-1:0]   addr_view,
    output logic [CA_W-1:0]   cnt_view
);
    logic [BASE_W-1:0] base_addr;
    logic [BASE_W-1:0] reload_src;
    logic              reload;
    localparam logic [CA_W-1:0] STEP = CA_W'(1) << SHIFT;

    always_comb begin
        reload     = base_we & hi_byte;
        reload_src = {(sel_cnt ? base_addr[15:8] : wdata), base_addr[7:0]};
        cnt_view   = (CA_W'(base_cnt) << SHIFT) - cur_cnt;
        addr_view  = mode[MODE_DEC_BIT] ? (cur_addr - cur_cnt) : (cur_addr + cur_cnt);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            base_addr <= '0;
            base_cnt  <= '0;
            cur_addr  <= '0;
            cur_cnt   <= '0;
            mode      <= '0;
        end else begin
            if (base_we) begin
                if (sel_cnt) begin
                    if (hi_byte) base_cnt[15:8]  <= wdata;
                    else         base_cnt[7:0]   <= wdata;
                end else begin
                    if (hi_byte) base_addr[15:8] <= wdata;
                    else         base_addr[7:0]  <= wdata;
                end
            end
            if (reload) begin
                cur_addr <= CA_W'(reload_src) << SHIFT;
                cur_cnt  <= '0;
            end else if (adv) begin
                cur_cnt  <= cur_cnt + STEP;
            end
            if (mode_we) mode <= wdata;
        end
    end
endmodule

// File: rtl/dma_regif_ctrl.sv
module dma_regif_ctrl
    import dma_regif_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              do_wr,
    input  logic              do_rd,
    input  port_sel_t         sel,
    input  logic [BYTE_W-1:0] wdata,
    input  logic [NCH-1:0]    eng_tc,
    output logic              byte_ff,
    output logic [NCH-1:0]    mask,
    output logic [2*NCH-1:0]  status,
    output logic [BYTE_W-1:0] command,
    output logic              cmd_unsup,
    output logic [BYTE_W-1:0] ctl_rdata
);
    logic              ctl_wr;
    logic              ctl_rd;
    logic [CH_W-1:0]   tch;
    logic [2*NCH-1:0]  status_nxt;
    logic [NCH-1:0]    mask_nxt;

    always_comb begin
        ctl_wr = do_wr & ~sel.in_chan;
        ctl_rd = do_rd & ~sel.in_chan;
        tch    = wdata[CH_W-1:0];

        status_nxt = status;
        mask_nxt   = mask;
        if (ctl_wr) begin
            unique case (sel.op)
                OP_REQ: begin
                    if (wdata[2]) begin
                        status_nxt[NCH + int'(tch)] = 1'b1;
                    end else begin
                        status_nxt[NCH + int'(tch)] = 1'b0;
                        status_nxt[int'(tch)]       = 1'b0;
                    end
                end
                OP_SMASK:   mask_nxt[int'(tch)] = wdata[2];
                OP_CLRMASK: mask_nxt = '0;
                OP_LDMASK:  mask_nxt = wdata[NCH-1:0];
                OP_MCLR: begin
                    status_nxt = '0;
                    mask_nxt   = '1;
                end
                default: ;
            endcase
        end
        if (ctl_rd && sel.op == OP_CMD) status_nxt[NCH-1:0] = '0;
        status_nxt[NCH-1:0] = status_nxt[NCH-1:0] | eng_tc;

        unique case (sel.op)
            OP_CMD:  ctl_rdata = status;
            OP_REQ:  ctl_rdata = {{(BYTE_W-NCH){1'b0}}, mask};
            default: ctl_rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            byte_ff   <= 1'b0;
            mask      <= '1;
            status    <= '0;
            command   <= '0;
            cmd_unsup <= 1'b0;
        end else begin
            mask   <= mask_nxt;
            status <= status_nxt;
            if (ctl_wr && (sel.op == OP_CLRFF || sel.op == OP_MCLR)) begin
                byte_ff <= 1'b0;
            end else if ((do_wr || do_rd) && sel.in_chan) begin
                byte_ff <= ~byte_ff;
            end
            if (ctl_wr && sel.op == OP_CMD) begin
                command   <= wdata;
                cmd_unsup <= |(wdata & CMD_UNSUP_BITS);
            end else if (ctl_wr && sel.op == OP_MCLR) begin
                command   <= '0;
                cmd_unsup <= 1'b0;
            end
        end
    end
endmodule

// File: rtl/dma_regif.sv
module dma_regif
    import dma_regif_pkg::*;
#(
    parameter int SHIFT = 0,
    localparam int CA_W = BASE_W + SHIFT,
    localparam int AW   = IDX_W + SHIFT
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic                  rd_en,
    input  logic [AW-1:0]         addr,
    input  logic [BYTE_W-1:0]     wdata,
    output logic [BYTE_W-1:0]     rdata,
    output logic                  rd_valid,
    input  logic [NCH-1:0]        eng_adv,
    input  logic [NCH-1:0]        eng_tc,
    output logic [NCH*BYTE_W-1:0] chan_mode,
    output logic [NCH*BASE_W-1:0] chan_base_cnt,
    output logic [NCH*CA_W-1:0]   chan_cur_addr,
    output logic [NCH*CA_W-1:0]   chan_cur_cnt,
    output logic [NCH-1:0]        mask_o,
    output logic [NCH-1:0]        req_o,
    output logic                  cmd_disable,
    output logic                  cmd_unsup
);
    port_sel_t         sel;
    logic              do_wr;
    logic              do_rd;
    logic              byte_ff;
    logic [2*NCH-1:0]  status_q;
    logic [BYTE_W-1:0] command_q;
    logic [BYTE_W-1:0] ctl_rdata;
    logic [CA_W-1:0]   addr_view [NCH];
    logic [CA_W-1:0]   cnt_view  [NCH];
    logic [CA_W-1:0]   view_sel;
    logic [BYTE_W-1:0] chan_rdata;

    dma_regif_decode #(.SHIFT(SHIFT)) u_dec (
        .addr  (addr),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .sel   (sel),
        .do_wr (do_wr),
        .do_rd (do_rd)
    );

    dma_regif_ctrl u_ctrl (
        .clk       (clk),
        .rst       (rst),
        .do_wr     (do_wr),
        .do_rd     (do_rd),
        .sel       (sel),
        .wdata     (wdata),
        .eng_tc    (eng_tc),
        .byte_ff   (byte_ff),
        .mask      (mask_o),
        .status    (status_q),
        .command   (command_q),
        .cmd_unsup (cmd_unsup),
        .ctl_rdata (ctl_rdata)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        logic base_we_c;
        logic mode_we_c;
        assign base_we_c = do_wr & sel.in_chan & (sel.chan == CH_W'(c));
        assign mode_we_c = do_wr & ~sel.in_chan & (sel.op == OP_MODE)
                         & (wdata[CH_W-1:0] == CH_W'(c));

        dma_regif_chan #(.SHIFT(SHIFT)) u_chan (
            .clk       (clk),
            .rst       (rst),
            .base_we   (base_we_c),
            .sel_cnt   (sel.sel_cnt),
            .hi_byte   (byte_ff),
            .wdata     (wdata),
            .mode_we   (mode_we_c),
            .adv       (eng_adv[c]),
            .mode      (chan_mode[c*BYTE_W +: BYTE_W]),
            .base_cnt  (chan_base_cnt[c*BASE_W +: BASE_W]),
            .cur_addr  (chan_cur_addr[c*CA_W +: CA_W]),
            .cur_cnt   (chan_cur_cnt[c*CA_W +: CA_W]),
            .addr_view (addr_view[c]),
            .cnt_view  (cnt_view[c])
        );
    end

    always_comb begin
        view_sel   = sel.sel_cnt ? cnt_view[sel.chan] : addr_view[sel.chan];
        chan_rdata = BYTE_W'(view_sel >> (SHIFT + (byte_ff ? BYTE_W : 0)));
        req_o      = status_q[2*NCH-1:NCH];
        cmd_disable = command_q[CMD_DISABLE_BIT];
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata    <= '0;
            rd_valid <= 1'b0;
        end else begin
            rd_valid <= do_rd;
            if (do_rd) rdata <= sel.in_chan ? chan_rdata : ctl_rdata;
        end
    end
endmodule

// File: rtl/dma_regif_chk.sv
module dma_regif_chk
    import dma_regif_pkg::*;
#(
    parameter int SHIFT = 0
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    wr_en,
    input logic                    rd_en,
    input logic [IDX_W+SHIFT-1:0]  addr,
    input logic [BYTE_W-1:0]       wdata,
    input logic [NCH-1:0]          eng_tc,
    input logic [NCH-1:0]          mask_o,
    input logic [NCH-1:0]          req_o,
    input logic                    rd_valid,
    input logic [BYTE_W-1:0]       rdata,
    input logic                    byte_ff,
    input logic [2*NCH-1:0]        status_q,
    input logic                    cmd_unsup
);
    logic [IDX_W-1:0] idx;
    assign idx = addr[SHIFT +: IDX_W];

    // R2: any channel register access flips the byte pointer
    a_r2_ptr_flips: assert property (@(posedge clk) disable iff (rst)
        ((wr_en || rd_en) && idx < 4'd8) |=> (byte_ff != $past(byte_ff)));

    // R7: clear-all and load-all mask writes
    a_r7_mask_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == 4'd14) |=> (mask_o == '0));
    a_r7_mask_load: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == 4'd15) |=> (mask_o == $past(wdata[NCH-1:0])));

    // R9: master clear
    a_r9_master_clear: assert property (@(posedge clk) disable iff (rst)
        (wr_en && idx == 4'd13) |=> (mask_o == '1 && req_o == '0 && !byte_ff && !cmd_unsup));

    // R11: an engine terminal count is never lost
    a_r11_tc_kept: assert property (@(posedge clk) disable iff (rst)
        (|eng_tc) |=> ((status_q[NCH-1:0] & $past(eng_tc)) == $past(eng_tc)));

    // R10: undefined read offsets return zero
    a_r10_undef_zero: assert property (@(posedge clk) disable iff (rst)
        (rd_en && !wr_en && idx >= 4'd10) |=> (rd_valid && rdata == '0));

    // R14: a write cycle never yields read data
    a_r14_write_wins: assert property (@(posedge clk) disable iff (rst)
        wr_en |=> !rd_valid);
endmodule

bind dma_regif dma_regif_chk #(.SHIFT(SHIFT)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .rd_en     (rd_en),
    .addr      (addr),
    .wdata     (wdata),
    .eng_tc    (eng_tc),
    .mask_o    (mask_o),
    .req_o     (req_o),
    .rd_valid  (rd_valid),
    .rdata     (rdata),
    .byte_ff   (byte_ff),
    .status_q  (status_q),
    .cmd_unsup (cmd_unsup)
);

// File: tb/dma_regif_tb.sv
module dma_regif_tb;
    localparam int SH   = 1;
    localparam int CA_W = 16 + SH;
    localparam int AW   = 4 + SH;

    logic            clk = 1'b0;
    logic            rst = 1'b1;
    logic            wr_en = 1'b0;
    logic            rd_en = 1'b0;
    logic [AW-1:0]   addr = '0;
    logic [7:0]      wdata = '0;
    logic [7:0]      rdata;
    logic            rd_valid;
    logic [3:0]      eng_adv = '0;
    logic [3:0]      eng_tc = '0;
    logic [31:0]     chan_mode;
    logic [63:0]     chan_base_cnt;
    logic [4*CA_W-1:0] chan_cur_addr;
    logic [4*CA_W-1:0] chan_cur_cnt;
    logic [3:0]      mask_o;
    logic [3:0]      req_o;
    logic            cmd_disable;
    logic            cmd_unsup;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;
    bit junk = 0;
    logic [7:0] exp_q[$];
    string      tag_q[$];

    always #5 clk = ~clk;

    dma_regif #(.SHIFT(SH)) u_dut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
        .wdata(wdata), .rdata(rdata), .rd_valid(rd_valid),
        .eng_adv(eng_adv), .eng_tc(eng_tc), .chan_mode(chan_mode),
        .chan_base_cnt(chan_base_cnt), .chan_cur_addr(chan_cur_addr),
        .chan_cur_cnt(chan_cur_cnt), .mask_o(mask_o), .req_o(req_o),
        .cmd_disable(cmd_disable), .cmd_unsup(cmd_unsup)
    );

    task automatic check(string tag, longint act, longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    // monitor: pops expected read bytes as the design returns them
    always @(negedge clk) begin
        if (!rst && rd_valid) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R14 unexpected read data actual=0x%0h expected=none", rdata);
            end else begin
                check(tag_q.pop_front(), rdata, exp_q.pop_front());
            end
        end
    end

    task automatic access(bit w, bit r, int idx, int d, logic [3:0] adv, logic [3:0] tc);
        @(negedge clk);
        junk  = ~junk;
        addr  = AW'((idx << SH) | int'(junk));
        wdata = 8'(d);
        wr_en = w; rd_en = r; eng_adv = adv; eng_tc = tc;
        @(negedge clk);
        wr_en = 0; rd_en = 0; eng_adv = '0; eng_tc = '0;
    endtask

    task automatic wr(int idx, int d);
        access(1, 0, idx, d, '0, '0);
    endtask

    task automatic rd(int idx, int exp, string tag, logic [3:0] tc = '0);
        exp_q.push_back(8'(exp));
        tag_q.push_back(tag);
        access(0, 1, idx, 0, '0, tc);
    endtask

    function automatic int byte_of(int v, int hi);
        return (v >> (SH + 8 * hi)) & 8'hFF;
    endfunction

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        // R13 reset state
        check("R13 mask", mask_o, 4'hF);
        check("R13 req", req_o, 0);
        check("R13 rd_valid", rd_valid, 0);
        rd(8, 8'h00, "R13 status after reset");
        rd(9, 8'h0F, "R10 mask read after reset");

        // R1 R2 R3 R4: channel 1 start address and count
        wr(2, 8'h34); wr(2, 8'h12);
        check("R3 reload addr", chan_cur_addr[1*CA_W +: CA_W], 32'h1234 << SH);
        rd(2, byte_of(32'h1234 << SH, 0), "R4 addr low");
        rd(2, byte_of(32'h1234 << SH, 1), "R1 R4 addr high");
        wr(3, 8'hFF); wr(3, 8'h00);
        check("R2 base count", chan_base_cnt[16 +: 16], 16'h00FF);
        rd(3, 8'hFF, "R4 count low");
        rd(3, 8'h00, "R4 count high");

        // R12 engine advance
        repeat (3) access(0, 0, 0, 0, 4'b0010, '0);
        check("R12 cur_cnt", chan_cur_cnt[1*CA_W +: CA_W], 3 << SH);
        rd(3, byte_of((8'hFF << SH) - (3 << SH), 0), "R4 count after advance");
        rd(3, 8'h00, "R4 count high after advance");
        rd(2, byte_of((16'h1234 << SH) + (3 << SH), 0), "R4 addr incr low");
        rd(2, byte_of((16'h1234 << SH) + (3 << SH), 1), "R4 addr incr high");

        // R8 mode, decrement direction
        wr(11, 8'h21);
        check("R8 mode ch1", chan_mode[8 +: 8], 8'h21);
        check("R8 mode ch0 untouched", chan_mode[0 +: 8], 8'h00);
        rd(2, byte_of((16'h1234 << SH) - (3 << SH), 0), "R4 addr decr low");
        rd(2, byte_of((16'h1234 << SH) - (3 << SH), 1), "R4 addr decr high");

        // R2 pointer clear
        wr(2, 8'hAA);
        wr(12, 0);
        wr(2, 8'h55);
        check("R2 R3 low write no reload", chan_cur_addr[1*CA_W +: CA_W], 32'h1234 << SH);
        wr(2, 8'h56);
        check("R3 reload new addr", chan_cur_addr[1*CA_W +: CA_W], 32'h5655 << SH);
        check("R3 reload count zero", chan_cur_cnt[1*CA_W +: CA_W], 0);

        // R3 reload beats advance
        access(0, 0, 0, 0, 4'b0010, '0);
        check("R12 single advance", chan_cur_cnt[1*CA_W +: CA_W], 1 << SH);
        wr(3, 8'h10);
        access(1, 0, 3, 8'h00, 4'b0010, '0);
        check("R3 reload wins over advance", chan_cur_cnt[1*CA_W +: CA_W], 0);
        check("R3 count start", chan_base_cnt[16 +: 16], 16'h0010);

        // R5 command
        wr(8, 8'h04);
        check("R5 disable", cmd_disable, 1);
        check("R5 supported", cmd_unsup, 0);
        wr(8, 8'h01);
        check("R5 unsupported", cmd_unsup, 1);
        check("R5 disable off", cmd_disable, 0);
        wr(8, 8'h00);
        check("R5 zero command", cmd_unsup, 0);

        // R6 R10 R11 request and status
        wr(9, 8'h06);
        check("R6 request set", req_o, 4'b0100);
        access(0, 0, 0, 0, '0, 4'b0100);
        rd(8, 8'h44, "R10 status read");
        rd(8, 8'h40, "R10 tc cleared by read");
        access(0, 0, 0, 0, '0, 4'b0100);
        wr(9, 8'h02);
        check("R6 request cleared", req_o, 0);
        rd(8, 8'h00, "R6 tc cleared by request write");
        rd(8, 8'h00, "R11 read during tc", 4'b0001);
        rd(8, 8'h01, "R11 tc survives read");
        rd(8, 8'h00, "R11 tc then cleared");

        // R7 masks
        wr(14, 0);
        check("R7 clear all", mask_o, 0);
        wr(10, 8'h07);
        check("R7 single set", mask_o, 4'b1000);
        wr(10, 8'h03);
        check("R7 single clear", mask_o, 0);
        wr(15, 8'h05);
        rd(9, 8'h05, "R7 R10 mask read");

        // R10 undefined reads
        for (int i = 10; i < 16; i++) rd(i, 8'h00, "R10 undefined read");

        // R14 write and read together
        access(1, 1, 15, 8'h03, '0, '0);
        check("R14 no read data", rd_valid, 0);
        check("R14 write done", mask_o, 4'h3);

        // R9 master clear
        wr(9, 8'h05);
        wr(8, 8'h01);
        wr(0, 8'h11);
        wr(13, 0);
        check("R9 mask set", mask_o, 4'hF);
        check("R9 req cleared", req_o, 0);
        check("R9 unsup cleared", cmd_unsup, 0);
        check("R9 mode kept", chan_mode[8 +: 8], 8'h21);
        rd(8, 8'h00, "R9 status cleared");
        wr(0, 8'h22); wr(0, 8'h33);
        check("R9 pointer cleared", chan_cur_addr[0 +: CA_W], 32'h3322 << SH);

        repeat (4) @(negedge clk);
        if (exp_q.size() != 0) begin
            n_cmp++; n_bad++;
            $display("FAIL R4 missing read data actual=%0d expected=0 pending", exp_q.size());
        end
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule